// File: doc/BRIEF.md
# Serial Register Port with Selectable Wire Mode and Bit Order

This block is a synchronous serial slave that lets a host read and write a small bank of byte-wide registers. The host frames each access with an active-low select. The first byte it shifts in is an instruction. The bytes that follow carry data: the host sends them on a write, and the port sends them back on a read. The serial clock, select and input data are synchronized into the system clock domain, and the port acts on the detected serial clock edges. It therefore works whether the host parks the serial clock low or high between accesses.

Register 0 configures the port itself. Bit 0 selects 3-wire readback, where read data leaves on a separate `sdo` output. When it is clear, read data comes back on the bidirectional data line, which turns around after the instruction. Bit 1 selects LSB-first shifting, and it applies to both the instruction and the data. A transaction uses the configuration that was in force when it began. Dropping the select early abandons the transaction, and no partial byte is written.

Top module: `sregp_port`

## Requirements
- R1: After reset every register reads 0x00, the port is in 2-wire MSB-first mode, and both output enables are low.
- R2: The first byte of a frame is the instruction. Its logical bit 7 set to 1 means read, and its bits [2:0] give the register address. On a write, each data byte is stored to the addressed register only once all 8 of its bits have been received.
- R3: After each data byte, the address advances by one and wraps from register 7 to register 0. This applies to both reads and writes.
- R4: Input bits are sampled on the rising serial clock edge, and output bits change only on the falling edge. Transactions work with the serial clock idling either low or high.
- R5: With register 0 bit 0 clear, read data is driven on `sdio_o` with `sdio_oe_o` high during the read data phase, and `sdo_oe_o` stays low.
- R6: With register 0 bit 0 set, read data is driven on `sdo_o` with `sdo_oe_o` high, and `sdio_oe_o` stays low throughout the read data phase.
- R7: With register 0 bit 1 set, the instruction and every data byte are shifted least significant bit first. With it clear, they are shifted most significant bit first.
- R8: A change to register 0 takes effect from the next frame. Any later bytes in the same frame keep the old wire mode and bit order.
- R9: Raising `cs_ni` mid-frame aborts the transaction. Both output enables drop, the bit count and phase restart, and a partially received byte is not written.
- R10: `sdio_oe_o` and `sdo_oe_o` are never high together, and both are low while the select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host serial clock |
| cs_ni | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output side (2-wire readback) |
| sdio_oe_o | output | 1 | Data line output enable |
| sdo_o | output | 1 | Dedicated read data output (3-wire readback) |
| sdo_oe_o | output | 1 | Dedicated output enable |

## Verification
The host model runs writes and reads under both serial clock idle levels. A design that samples on the wrong edge, or that counts the idle-high leading fall as a bit, loses bits under only one of the two polarities. Each of the four combinations of wire mode and bit order is exercised. A readback on the wrong pin shows up in the output-enable checks, and a byte shifted in the wrong order shows up as a value mismatch. A multi-byte frame starting at register 7 checks the address wrap. A frame that rewrites register 0 and then continues separates a configuration latched per frame from one applied at once. Aborted writes and reads check that no partial byte is committed and that the outputs release.

// File: rtl/sregp_pkg.sv
package sregp_pkg;
  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  localparam int CTRL_SDO_BIT = 0;
  localparam int CTRL_LSB_BIT = 1;
endpackage

// File: rtl/sregp_sync.sv
module sregp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{rst_val_i[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sregp_regfile.sv
module sregp_regfile #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(r)) regs_q[r] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= regs_q[rd_addr_i];
  end

  assign ctrl_o = regs_q[0];

  AST_WR_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(wr_addr_i)] == $past(wr_data_i)); // R2
endmodule

// File: rtl/sregp_framer.sv
module sregp_framer
  import sregp_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic              cfg_lsb_i,
  input  logic              cfg_3w_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q, shift_next;
  logic [ADDR_W-1:0] addr_q;
  logic              out_q, oe_q;
  logic              byte_done, instr_rd;
  logic [CNT_W-1:0]  out_idx;

  always_comb begin
    if (cfg_lsb_i) shift_next = {sdi_i, shreg_q[DATA_W-1:1]};
    else           shift_next = {shreg_q[DATA_W-2:0], sdi_i};
  end

  assign byte_done = cs_act_i && sclk_rise_i && (cnt_q == LAST_BIT);
  assign instr_rd  = shift_next[DATA_W-1];
  assign out_idx   = cfg_lsb_i ? cnt_q : (LAST_BIT - cnt_q);

  // fetch the next read byte as the current byte closes
  assign rd_en_o   = byte_done && ((phase_q == PH_INSTR && instr_rd) || phase_q == PH_READ);
  assign rd_addr_o = (phase_q == PH_INSTR) ? shift_next[ADDR_W-1:0] : addr_q + 1'b1;

  assign wr_en_o   = byte_done && (phase_q == PH_WRITE);
  assign wr_addr_o = addr_q;
  assign wr_data_o = shift_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_INSTR;
      cnt_q   <= '0;
      shreg_q <= '0;
      addr_q  <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!cs_act_i) begin
      phase_q <= PH_INSTR;
      cnt_q   <= '0;
      shreg_q <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (sclk_rise_i) begin
        cnt_q   <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        shreg_q <= shift_next;
        if (byte_done) begin
          if (phase_q == PH_INSTR) begin
            addr_q  <= shift_next[ADDR_W-1:0];
            phase_q <= instr_rd ? PH_READ : PH_WRITE;
          end else begin
            addr_q  <= addr_q + 1'b1;
          end
        end
      end
      if (sclk_fall_i && phase_q == PH_READ) begin
        out_q <= rd_data_i[out_idx];
        oe_q  <= 1'b1;
      end
    end
  end

  assign sdio_o    = out_q;
  assign sdo_o     = out_q;
  assign sdio_oe_o = oe_q && !cfg_3w_i;
  assign sdo_oe_o  = oe_q && cfg_3w_i;

  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !sdio_oe_o && !sdo_oe_o); // R9
  AST_OUT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && $past(oe_q) && !$stable(out_q)) |-> $past(sclk_fall_i)); // R4
  AST_NO_OE_OUTSIDE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> phase_q == PH_READ); // R5
endmodule

// File: rtl/sregp_port.sv
module sregp_port
  import sregp_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [2:0] raw, synced;
  logic       sclk_s, cs_s, sdi_s, sclk_d;
  logic       cs_act, sclk_rise, sclk_fall;
  logic       cfg_lsb_q, cfg_3w_q;

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data, ctrl;

  assign raw = {sclk_i, cs_ni, sdio_i};

  sregp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (raw),
    .rst_val_i (3'b010),
    .q_o       (synced)
  );

  assign {sclk_s, cs_s, sdi_s} = synced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign cs_act    = !cs_s;
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  // configuration frozen for the whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lsb_q <= 1'b0;
      cfg_3w_q  <= 1'b0;
    end else if (!cs_act) begin
      cfg_lsb_q <= ctrl[CTRL_LSB_BIT];
      cfg_3w_q  <= ctrl[CTRL_SDO_BIT];
    end
  end

  sregp_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sdi_i       (sdi_s),
    .cfg_lsb_i   (cfg_lsb_q),
    .cfg_3w_i    (cfg_3w_q),
    .rd_data_i   (rd_data),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  sregp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .ctrl_o    (ctrl)
  );

  AST_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o)); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_act)) |-> ($stable(cfg_lsb_q) && $stable(cfg_3w_q))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act && $past(!cs_act)) |-> (!sdio_oe_o && !sdo_oe_o)); // R10
endmodule

// File: tb/sregp_port_test.sv
module sregp_port_test;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o, sdo_oe_o;

  int checks = 0, fails = 0, cs_hi_cnt = 0;
  bit done = 1'b0;
  logic [7:0] mdl [8];
  logic [7:0] wbuf [16];

  always #5 clk = ~clk;

  sregp_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock: exclusive enables, silent when idle
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(!(sdio_oe_o && sdo_oe_o), "R10 exclusive enables", {sdio_oe_o, sdo_oe_o}, 0);
      cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
      if (cs_hi_cnt >= 4)
        chk(!sdio_oe_o && !sdo_oe_o, "R9/R10 idle release", {sdio_oe_o, sdo_oe_o}, 0);
    end
  end

  task automatic put_bit(input bit b);
    sclk = 1'b0; sdi = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic get_bit(input bit three_w, output bit b, output bit oe_ok);
    sclk = 1'b0; sdi = 1'b0;
    repeat (H) @(negedge clk);
    b     = three_w ? sdo_o : sdio_o;
    oe_ok = three_w ? (sdo_oe_o && !sdio_oe_o) : (sdio_oe_o && !sdo_oe_o);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // cut: abort after this many bits (0 = full frame)
  task automatic xfer(input bit idle_hi, input bit rd, input int addr, input int nbytes,
                      input int cut, input string req);
    bit lsb, tw, b, ok, oe_all;
    logic [7:0] instr, got;
    int nbits = 0, a;
    lsb = mdl[0][1]; tw = mdl[0][0];
    sclk = idle_hi;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    instr = {rd, 4'b0, 3'(addr)};
    for (int i = 0; i < 8; i++) begin
      put_bit(lsb ? instr[i] : instr[7-i]);
      nbits++;
      if (nbits == cut) break;
    end
    if (cut == 0 || nbits < cut) begin
      for (int k = 0; k < nbytes; k++) begin
        a = (addr + k) % 8;
        oe_all = 1'b1;
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
          if (rd) begin
            get_bit(tw, b, ok);
            oe_all &= ok;
            if (lsb) got[i] = b; else got[7-i] = b;
          end else begin
            put_bit(lsb ? wbuf[k][i] : wbuf[k][7-i]);
          end
          nbits++;
          if (nbits == cut) break;
        end
        if (cut != 0 && nbits == cut) break;
        if (rd) begin
          chk(got == mdl[a], req, got, mdl[a]);
          chk(oe_all, tw ? "R6 sdo drives, sdio quiet" : "R5 sdio drives, sdo quiet", oe_all, 1);
        end else begin
          mdl[a] = wbuf[k];
        end
      end
    end
    if (cut != 0) begin
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(!sdio_oe_o && !sdo_oe_o, "R9 abort releases outputs", {sdio_oe_o, sdo_oe_o}, 0);
      sclk = idle_hi;
    end else begin
      if (!idle_hi) begin
        sclk = 1'b0;
        repeat (H) @(negedge clk);
      end
      cs_n = 1'b1;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!sdio_oe_o && !sdo_oe_o, "R1 reset enables low", {sdio_oe_o, sdo_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1: all registers read zero, 2-wire MSB-first
    xfer(1'b0, 1'b1, 0, 8, 0, "R1 reset register value");

    // R2 R3 R4: multi-byte write idle-high, read idle-low and idle-high
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    xfer(1'b1, 1'b0, 1, 3, 0, "R2 write");
    xfer(1'b0, 1'b1, 1, 3, 0, "R2/R4 read idle-low");
    xfer(1'b1, 1'b1, 1, 3, 0, "R3/R4 read idle-high");

    // R3: wrap from reg 7 to reg 0 (reg0 stays 0)
    wbuf[0] = 8'h5A; wbuf[1] = 8'h00; wbuf[2] = 8'hE7;
    xfer(1'b0, 1'b0, 7, 3, 0, "R3 wrap write");
    xfer(1'b1, 1'b1, 7, 3, 0, "R3 wrap read");

    // R6: 3-wire, MSB first
    wbuf[0] = 8'h01;
    xfer(1'b0, 1'b0, 0, 1, 0, "R6 set 3-wire");
    xfer(1'b0, 1'b1, 1, 2, 0, "R6 3-wire read idle-low");
    xfer(1'b1, 1'b1, 1, 2, 0, "R6 3-wire read idle-high");

    // R7: 3-wire, LSB first
    wbuf[0] = 8'h03;
    xfer(1'b1, 1'b0, 0, 1, 0, "R7 set lsb");
    wbuf[0] = 8'h96;
    xfer(1'b0, 1'b0, 4, 1, 0, "R7 lsb write");
    xfer(1'b0, 1'b1, 4, 1, 0, "R7 lsb 3-wire read");
    xfer(1'b1, 1'b1, 1, 3, 0, "R7 lsb 3-wire read idle-high");

    // R5 R7: 2-wire, LSB first
    wbuf[0] = 8'h02;
    xfer(1'b0, 1'b0, 0, 1, 0, "R7 set 2-wire lsb");
    wbuf[0] = 8'h4B; wbuf[1] = 8'hD2;
    xfer(1'b1, 1'b0, 5, 2, 0, "R7 lsb 2-wire write");
    xfer(1'b0, 1'b1, 5, 2, 0, "R5/R7 lsb 2-wire read");
    xfer(1'b1, 1'b1, 0, 1, 0, "R5/R7 lsb ctrl read");

    // R8: same frame rewrites ctrl then writes reg1 with old order
    wbuf[0] = 8'h00; wbuf[1] = 8'hC1;
    xfer(1'b0, 1'b0, 0, 2, 0, "R8 ctrl change mid-frame");
    xfer(1'b0, 1'b1, 1, 1, 0, "R8 old order held in frame");
    xfer(1'b1, 1'b1, 0, 1, 0, "R8 new order next frame");

    // R9: abort write after 4 data bits, abort read mid-byte
    wbuf[0] = 8'hFF;
    xfer(1'b0, 1'b0, 5, 1, 12, "R9 abort write");
    xfer(1'b1, 1'b1, 5, 1, 0, "R9 no partial write");
    xfer(1'b0, 1'b1, 2, 1, 13, "R9 abort read");
    xfer(1'b0, 1'b1, 2, 1, 0, "R9 frame after abort");
    wbuf[0] = 8'hFF;
    xfer(1'b1, 1'b0, 6, 1, 5, "R9 abort in instruction");
    xfer(1'b0, 1'b1, 6, 1, 0, "R9 reg6 intact");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule